// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block shifts the second operand of a data-processing datapath and works out the shifter carry-out that goes with it. It takes a data word, a two-bit shift kind, a shift amount and the incoming carry flag. A select bit picks the amount source. It is either a short immediate field that is as wide as needed to index one bit of the word, or the low byte of a register.

The immediate and register forms treat the edge amounts in different ways. An immediate amount of zero stands for a different operation for each shift kind. A register amount of zero always leaves the operand alone. Register amounts that reach or pass the word width have their own rules for the result and the carry. The result and the carry are registered, so they appear one clock after the inputs are sampled. A synchronous active-high reset clears both outputs.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, both `res_out` and `carry_out` are 0 after that edge.
- R2: The shift kind code is 0 for logical left, 1 for logical right, 2 for arithmetic right and 3 for rotate right. For an immediate amount n from 1 to 31, a right shift or rotate gives carry value[n-1], and a left shift gives carry value[32-n].
- R3: An immediate logical left shift by 0 returns the value unchanged and keeps the incoming carry.
- R4: An immediate logical right shift by 0 acts as a shift by 32. The result is 0 and the carry is value[31].
- R5: An immediate arithmetic right shift by 0 fills every result bit with value[31], and the carry is value[31].
- R6: An immediate rotate by 0 is a one-bit rotate through the carry. The result is {carry_in, value[31:1]} and the carry is value[0].
- R7: A register amount of 0 returns the value unchanged and keeps the incoming carry, for every shift kind.
- R8: A register amount from 1 to 31 gives the same result and carry as the same immediate amount, for every shift kind.
- R9: For a logical left or logical right register shift of 32 or more, the result is 0. At exactly 32 the carry is value[0] for a left shift and value[31] for a right shift. Above 32 the carry is 0.
- R10: An arithmetic right register shift of 32 or more fills the result with value[31], and the carry is value[31].
- R11: A register rotate uses the amount modulo 32. A nonzero amount whose low five bits are zero returns the value unchanged, with carry value[31].
- R12: The outputs reflect the inputs sampled at the previous rising edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 32 | Operand to shift |
| shift_kind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| use_reg | input | 1 | 1 selects the register amount, 0 selects the immediate amount |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 8 | Register shift amount (low byte) |
| carry_in | input | 1 | Incoming carry flag |
| res_out | output | 32 | Registered shifted operand |
| carry_out | output | 1 | Registered shifter carry-out |

## Verification
Operands with distinct patterns at both ends are used: bit 31 and bit 0 set, an inverted pattern, and a mixed word. With these, a wrong sign fill, a wrong carry bit index or a swapped rotate direction each gives a visibly different result. Every shift kind is swept over immediate amounts 0, 1, 5 and 31, and over register amounts 0, 1, 17, 31, 32, 33, 64, 200 and 255, with both carry-in values. This separates the zero-amount special cases, the exact-width carry and the above-width carry, and it shows whether the rotate amount is reduced modulo 32. Random inputs follow, and a reset in the middle of the run and a check that the outputs hold between edges cover the timing.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;
endpackage

// File: rtl/opsh_amount.sv
// Maps the selected amount source onto one effective amount plus two
// special-operation flags (pass-through, rotate through carry).
module opsh_amount
  import opsh_pkg::*;
#(
  parameter int W      = 32,
  parameter int RAMT_W = 8,
  parameter int LW     = 5,
  parameter int EFF_W  = 8
) (
  input  sh_kind_e            kind,
  input  logic                use_reg,
  input  logic [LW-1:0]       imm_amt,
  input  logic [RAMT_W-1:0]   reg_amt,
  output logic [EFF_W-1:0]    eff,
  output logic                pass,
  output logic                rrx
);
  localparam logic [EFF_W-1:0] FULL = EFF_W'(W);

  always_comb begin
    pass = 1'b0;
    rrx  = 1'b0;
    if (!use_reg) begin
      eff = EFF_W'(imm_amt);
      if (imm_amt == '0) begin
        case (kind)
          SH_LSL:  pass = 1'b1;
          SH_ROR:  rrx  = 1'b1;
          default: eff  = FULL;   // right shifts: zero encodes full width
        endcase
      end
    end else begin
      eff = EFF_W'(reg_amt);
      if (reg_amt == '0) begin
        pass = 1'b1;
      end else if (kind == SH_ROR) begin
        // modulo width; a multiple of the width rotates by the full width
        eff = (reg_amt[LW-1:0] == '0) ? FULL : EFF_W'(reg_amt[LW-1:0]);
      end
    end
  end
endmodule

// File: rtl/opsh_rotator.sv
// Logarithmic right rotator, one stage per amount bit.
module opsh_rotator #(
  parameter int W  = 32,
  parameter int LW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [LW-1:0] k,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:LW];

  assign stage[0] = din;

  for (genvar g = 0; g < LW; g++) begin : g_stage
    localparam int SH = 1 << g;
    assign stage[g+1] = k[g] ? {stage[g][SH-1:0], stage[g][W-1:SH]} : stage[g];
  end

  assign dout = stage[LW];
endmodule

// File: rtl/opsh_core.sv
// Builds result and carry from the effective amount using one rotator.
module opsh_core
  import opsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int LW    = 5,
  parameter int EFF_W = 8
) (
  input  logic [W-1:0]     v,
  input  sh_kind_e         kind,
  input  logic [EFF_W-1:0] eff,
  input  logic             pass,
  input  logic             rrx,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam logic [EFF_W-1:0] FULL = EFF_W'(W);

  logic             big, over, sign;
  logic [EFF_W-1:0] neg, dec;
  logic [LW-1:0]    rot_k, idx_r;
  logic [W-1:0]     rot, rmask, lmask;

  assign big   = (eff >= FULL);
  assign over  = (eff > FULL);
  assign sign  = v[W-1];
  assign neg   = FULL - eff;
  assign dec   = eff - 1'b1;
  assign idx_r = dec[LW-1:0];
  // a left shift by n equals a right rotate by W-n, then masked
  assign rot_k = (kind == SH_LSL) ? neg[LW-1:0] : eff[LW-1:0];
  assign rmask = big ? '0 : ({W{1'b1}} >> eff);
  assign lmask = big ? '0 : ({W{1'b1}} << eff);

  opsh_rotator #(.W(W), .LW(LW)) u_rot (
    .din  (v),
    .k    (rot_k),
    .dout (rot)
  );

  always_comb begin
    res  = v;
    cout = cin;
    if (rrx) begin
      res  = {cin, v[W-1:1]};
      cout = v[0];
    end else if (!pass) begin
      case (kind)
        SH_LSL: begin
          res  = rot & lmask;
          cout = over ? 1'b0 : v[rot_k];
        end
        SH_LSR: begin
          res  = rot & rmask;
          cout = over ? 1'b0 : v[idx_r];
        end
        SH_ASR: begin
          res  = big ? {W{sign}} : ((rot & rmask) | (~rmask & {W{sign}}));
          cout = big ? sign : v[idx_r];
        end
        default: begin
          res  = rot;
          cout = v[idx_r];
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opsh_pkg::*;
#(
  parameter int W      = 32,
  parameter int RAMT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      src_val,
  input  logic [1:0]        shift_kind,
  input  logic              use_reg,
  input  logic [$clog2(W)-1:0] imm_amt,
  input  logic [RAMT_W-1:0] reg_amt,
  input  logic              carry_in,
  output logic [W-1:0]      res_out,
  output logic              carry_out
);
  localparam int LW    = $clog2(W);
  localparam int EFF_W = (RAMT_W > LW + 1) ? RAMT_W : LW + 1;

  sh_kind_e         kind;
  logic [EFF_W-1:0] eff;
  logic             pass, rrx, c_nxt;
  logic [W-1:0]     r_nxt;

  assign kind = sh_kind_e'(shift_kind);

  opsh_amount #(.W(W), .RAMT_W(RAMT_W), .LW(LW), .EFF_W(EFF_W)) u_amt (
    .kind    (kind),
    .use_reg (use_reg),
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .eff     (eff),
    .pass    (pass),
    .rrx     (rrx)
  );

  opsh_core #(.W(W), .LW(LW), .EFF_W(EFF_W)) u_core (
    .v    (src_val),
    .kind (kind),
    .eff  (eff),
    .pass (pass),
    .rrx  (rrx),
    .cin  (carry_in),
    .res  (r_nxt),
    .cout (c_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      carry_out <= 1'b0;
    end else begin
      res_out   <= r_nxt;
      carry_out <= c_nxt;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_out == '0 && !carry_out));

  // R7
  reg_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (use_reg && reg_amt == '0) |=>
      (res_out == $past(src_val) && carry_out == $past(carry_in)));

  // R3
  imm_lsl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!use_reg && imm_amt == '0 && shift_kind == 2'd0) |=>
      (res_out == $past(src_val) && carry_out == $past(carry_in)));

  // R6
  imm_rrx_chk: assert property (@(posedge clk) disable iff (rst)
    (!use_reg && imm_amt == '0 && shift_kind == 2'd3) |=>
      (res_out == {$past(carry_in), $past(src_val[W-1:1])} &&
       carry_out == $past(src_val[0])));

  // R9
  reg_logic_over_chk: assert property (@(posedge clk) disable iff (rst)
    (use_reg && !shift_kind[1] && int'(reg_amt) > W) |=>
      (res_out == '0 && !carry_out));

  // R10
  reg_asr_big_chk: assert property (@(posedge clk) disable iff (rst)
    (use_reg && shift_kind == 2'd2 && int'(reg_amt) >= W) |=>
      (res_out == {W{$past(src_val[W-1])}} && carry_out == $past(src_val[W-1])));
endmodule

// File: tb/tb_opnd_shifter.sv
`timescale 1ns/1ps
module tb_opnd_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_val = '0;
  logic [1:0]  shift_kind = '0;
  logic        use_reg = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_amt = '0;
  logic        carry_in = 1'b0;
  logic [31:0] res_out;
  logic        carry_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_r;
  bit          exp_c;
  string       exp_tag;
  bit          have_exp = 0;

  always #2.5 clk = ~clk;

  opnd_shifter dut (
    .clk(clk), .rst(rst), .src_val(src_val), .shift_kind(shift_kind),
    .use_reg(use_reg), .imm_amt(imm_amt), .reg_amt(reg_amt),
    .carry_in(carry_in), .res_out(res_out), .carry_out(carry_out)
  );

  function automatic void ref_model(input logic [31:0] v, input int kind,
      input bit ur, input int amt, input bit ci,
      output logic [31:0] r, output bit c);
    logic [63:0]        x;
    logic signed [63:0] sx;
    int n, m;
    r = v; c = ci;
    if (amt == 0) begin
      if (ur || kind == 0) return;
      case (kind)
        1: begin r = 32'h0; c = v[31]; end
        2: begin r = v[31] ? 32'hFFFF_FFFF : 32'h0; c = v[31]; end
        default: begin r = {ci, v[31:1]}; c = v[0]; end
      endcase
      return;
    end
    n = amt;
    case (kind)
      0: if (n > 32) begin r = 0; c = 0; end
         else begin x = {32'b0, v} << n; r = x[31:0]; c = x[32]; end
      1: if (n > 32) begin r = 0; c = 0; end
         else begin x = {v, 32'b0} >> n; r = x[63:32]; c = x[31]; end
      2: begin
        m = (n > 32) ? 32 : n;
        sx = $signed({v, 32'b0}) >>> m;
        r = sx[63:32]; c = sx[31];
      end
      default: begin
        m = n % 32;
        if (m == 0) begin r = v; c = v[31]; end
        else begin x = {v, v} >> m; r = x[31:0]; c = r[31]; end
      end
    endcase
  endfunction

  function automatic string req_tag(input int kind, input bit ur, input int amt);
    if (!ur) begin
      if (amt != 0) return "R2";
      case (kind)
        0: return "R3";
        1: return "R4";
        2: return "R5";
        default: return "R6";
      endcase
    end
    if (amt == 0) return "R7";
    if (amt < 32) return "R8";
    case (kind)
      0, 1: return "R9";
      2: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input bit ec);
    total++;
    if (res_out !== er || carry_out !== ec) begin
      bad++;
      $display("FAIL %s res=%h exp=%h carry=%b exp=%b", tag, res_out, er, carry_out, ec);
    end
  endtask

  task automatic step(input logic [31:0] v, input int kind, input bit ur,
      input int amt, input bit ci);
    int a;
    logic [31:0] nr;
    bit nc;
    @(negedge clk);
    if (have_exp) check(exp_tag, exp_r, exp_c);
    a = ur ? (amt & 255) : (amt & 31);
    src_val = v; shift_kind = kind[1:0]; use_reg = ur;
    imm_amt = a[4:0]; reg_amt = a[7:0]; carry_in = ci;
    // R12: outputs hold their registered value between edges
    #1;
    if (have_exp) check("R12", exp_r, exp_c);
    ref_model(v, kind, ur, a, ci, nr, nc);
    exp_r = nr; exp_c = nc; exp_tag = req_tag(kind, ur, a);
    have_exp = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    if (have_exp) check(exp_tag, exp_r, exp_c);
    rst = 1'b1;
    src_val = 32'hDEAD_BEEF; carry_in = 1'b1; use_reg = 1'b1; reg_amt = 8'd3;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rst = 1'b0;
    have_exp = 0;
  endtask

  initial begin
    logic [31:0] pats [3];
    int imms [4];
    int regs [9];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5C3_1E0F;
    imms = '{0, 1, 5, 31};
    regs = '{0, 1, 17, 31, 32, 33, 64, 200, 255};
    src_val = 32'h1234_5678; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 3; p++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int i = 0; i < 4; i++) step(pats[p], k, 1'b0, imms[i], ci[0]);
          for (int i = 0; i < 9; i++) step(pats[p], k, 1'b1, regs[i], ci[0]);
        end
    do_reset();
    for (int i = 0; i < 600; i++)
      step($urandom, $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 255), $urandom_range(0, 1));
    @(negedge clk);
    if (have_exp) check(exp_tag, exp_r, exp_c);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule